// File: doc/BRIEF.md
# Snapshot Capture Buffer Controller

This block records a burst of converter samples into a buffer memory that sits beside it and then holds the burst until a readback request arrives. A capture is triggered either by a level on a trigger pin, which can be delayed by a programmable hold-off, or by a one-cycle strobe from a register write. The burst length is a multiple of 64 samples. Two flags report the buffer state with fixed cycle latencies measured from the last trigger. A downstream serializer can use them to pace its readout.

Two capture styles are offered. Single capture records one burst after the trigger, and a second trigger during the burst starts it again. Continuous capture writes a circular window that wraps without end, and a trigger freezes it so that the history leading up to the event is kept. Readback then starts at the oldest retained sample. If the converter was left in standby after a previous burst, a new trigger first waits a programmable settle time while the converter wakes.

Top module: `snapshot_capture`

## Requirements
- R1: After reset `emptyFlag`=1, `fullFlag`=0, `convStandby`=0, and neither `memWe` nor `memRe` is asserted.
- R2: A single capture writes exactly N=(`fillLen`+1)×64 samples. The write addresses run upward from 0 to N-1, and `memWdata` carries `sampleIn`.
- R3: `emptyFlag` falls exactly 24 clock edges after the last edge at which the effective trigger was seen.
- R4: `fullFlag` rises exactly N+13 edges after the last effective trigger. No write occurs while `fullFlag` is high.
- R5: A trigger during a single capture restarts it. The timing of R3 and R4 and the address sequence of R2 are then counted from the new trigger.
- R6: A `swFill` strobe acts as a trigger with no hold-off.
- R7: With `holdOff`=H>0, a `fillPin` level sampled high at edge k takes effect at edge k+H. With H=0 it takes effect at edge k.
- R8: `fillMode` 2'b01 selects continuous capture. In this mode one sample is written every cycle from the trigger onward, and the address wraps at N. The next trigger stops writing, and `fullFlag` rises at that edge.
- R9: When `dumpReq` is high with `fullFlag` set, readback issues one `memRe` address per cycle. It starts at the oldest retained sample and wraps at N. It covers N samples, or all W samples when fewer than N were written. After the last read, `emptyFlag`=1 and `fullFlag`=0.
- R10: `dumpReq` has no effect while no captured data is held. Triggers have no effect while data waits for readback.
- R11: With `stbyAfter`=1, `convStandby` rises when a capture completes. The next trigger clears it and delays the capture start by `settleCnt` cycles. No write occurs while `convStandby` is high.
- R12: `fillMode` 2'b00 selects single capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rstN | input | 1 | Asynchronous reset, active low |
| fillPin | input | 1 | Trigger level from the pin, subject to hold-off |
| swFill | input | 1 | Trigger strobe from a register write |
| dumpReq | input | 1 | Readback request |
| fillMode | input | 2 | 00 single capture, 01 continuous capture |
| fillLen | input | 8 | Burst length code, N=(fillLen+1)×64 |
| holdOff | input | 16 | Delay of pin trigger, in cycles |
| settleCnt | input | 16 | Wake-up wait, in cycles |
| stbyAfter | input | 1 | Enter standby when a capture completes |
| sampleIn | input | 12 | Converter sample |
| memWe | output | 1 | Buffer write enable |
| memRe | output | 1 | Buffer read enable |
| memAddr | output | 14 | Buffer address for write or read |
| memWdata | output | 12 | Buffer write data |
| fullFlag | output | 1 | Capture complete, data held |
| emptyFlag | output | 1 | Buffer holds no unread data |
| convStandby | output | 1 | Converter standby request |

## Verification
The bench measures the flag edges to the exact cycle. This covers the plain case, a restarted capture, a hold-off and a settle wait, so an off-by-one in the latency counter or in the delay bookkeeping shows up as a flag that moves one cycle early or late. Continuous capture is stopped once after the window has wrapped and once before it has. A design that always read back from address 0, or that used a wrong read length, would return the wrong first or last address or the wrong number of reads. Spurious `dumpReq` in idle and spurious triggers during the wait are applied as well, and a design that reacted to them would show extra reads or a lost `fullFlag`.

// File: rtl/snap_pkg.sv
package snap_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_SETTLE, ST_FILL, ST_CONT, ST_WAIT, ST_READ
  } snapState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic wrClr;
    logic wrInc;
    logic rdLoad;
    logic rdInc;
  } snapStrb_t;

  localparam logic [1:0] MODE_SINGLE = 2'b00;
  localparam logic [1:0] MODE_CONT   = 2'b01;
endpackage

// File: rtl/snap_dpath.sv
module snap_dpath
  import snap_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int LEN_W  = 8,
  parameter int BLK_W  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  snapStrb_t         strb,
  input  logic [LEN_W-1:0]  fillLen,
  output logic              wrLast,
  output logic              rdLast,
  output logic [ADDR_W-1:0] memAddr
);
  localparam int CAP_W = ADDR_W + 1;

  logic [CAP_W-1:0]  capLen, rdLeft;
  logic [ADDR_W-1:0] wrPtr, rdPtr, lastIdx;
  logic              wrapped;

  assign capLen  = (CAP_W'(fillLen) + CAP_W'(1)) << BLK_W;
  assign lastIdx = ADDR_W'(capLen - CAP_W'(1));
  assign wrLast  = (wrPtr == lastIdx);
  assign rdLast  = (rdLeft == CAP_W'(1));
  assign memAddr = strb.rdInc ? rdPtr : wrPtr;

  function automatic logic [ADDR_W-1:0] nextIdx(input logic [ADDR_W-1:0] p);
    return (p == lastIdx) ? '0 : p + ADDR_W'(1);
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr   <= '0;
      wrapped <= 1'b0;
      rdPtr   <= '0;
      rdLeft  <= '0;
    end else begin
      if (strb.wrClr) begin
        wrPtr   <= '0;
        wrapped <= 1'b0;
      end else if (strb.wrInc) begin
        wrPtr <= nextIdx(wrPtr);
        if (wrLast) wrapped <= 1'b1;
      end
      if (strb.rdLoad) begin
        // oldest retained sample sits at the write pointer once wrapped
        rdPtr  <= wrapped ? wrPtr : '0;
        rdLeft <= wrapped ? capLen : {1'b0, wrPtr};
      end else if (strb.rdInc) begin
        rdPtr  <= nextIdx(rdPtr);
        rdLeft <= rdLeft - CAP_W'(1);
      end
    end
  end
endmodule

// File: rtl/snap_ctrl.sv
module snap_ctrl
  import snap_pkg::*;
#(
  parameter int HOLD_W    = 16,
  parameter int SETTLE_W  = 16,
  parameter int FILL_LAT  = 13,
  parameter int EMPTY_LAT = 24
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                fillPin,
  input  logic                swFill,
  input  logic                dumpReq,
  input  logic [1:0]          fillMode,
  input  logic [HOLD_W-1:0]   holdOff,
  input  logic [SETTLE_W-1:0] settleCnt,
  input  logic                stbyAfter,
  input  logic                wrLast,
  input  logic                rdLast,
  output snapStrb_t           strb,
  output logic                memWe,
  output logic                memRe,
  output logic                fullFlag,
  output logic                emptyFlag,
  output logic                convStandby
);
  localparam int CNT_W = $clog2(EMPTY_LAT + 1);

  snapState_t          state;
  logic [CNT_W-1:0]    cnt;
  logic [SETTLE_W-1:0] scnt;
  logic [HOLD_W-1:0]   hcnt;
  logic                pend;
  logic                trig, needSettle, beginCap;

  // effective trigger: strobe, undelayed pin, or hold-off expiry
  assign trig = swFill | (fillPin & (holdOff == '0)) | (pend & (hcnt == HOLD_W'(1)));
  assign needSettle = convStandby & (settleCnt != '0);

  always_comb begin
    beginCap = 1'b0;
    case (state)
      ST_IDLE:   beginCap = trig & ~needSettle;
      ST_SETTLE: beginCap = ~trig & (scnt == settleCnt - SETTLE_W'(1));
      ST_FILL:   beginCap = trig;
      default:   beginCap = 1'b0;
    endcase
  end

  always_comb begin
    strb        = '0;
    strb.wrClr  = beginCap;
    strb.wrInc  = (state == ST_CONT) |
                  ((state == ST_FILL) & ~trig & (cnt >= CNT_W'(FILL_LAT)));
    strb.rdLoad = (state == ST_WAIT) & dumpReq;
    strb.rdInc  = (state == ST_READ);
  end

  assign memWe = strb.wrInc;
  assign memRe = strb.rdInc;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      cnt         <= '0;
      scnt        <= '0;
      hcnt        <= '0;
      pend        <= 1'b0;
      fullFlag    <= 1'b0;
      emptyFlag   <= 1'b1;
      convStandby <= 1'b0;
    end else begin
      if (fillPin && holdOff != '0) begin
        pend <= 1'b1;
        hcnt <= holdOff;
      end else if (pend) begin
        hcnt <= hcnt - HOLD_W'(1);
        if (hcnt == HOLD_W'(1)) pend <= 1'b0;
      end

      if (state == ST_IDLE && trig) convStandby <= 1'b0;

      if (beginCap) begin
        state <= (state == ST_FILL || fillMode != MODE_CONT) ? ST_FILL : ST_CONT;
        cnt   <= '0;
      end else begin
        case (state)
          ST_IDLE: if (trig) begin
            state <= ST_SETTLE;
            scnt  <= '0;
          end
          ST_SETTLE: scnt <= trig ? '0 : scnt + SETTLE_W'(1);
          ST_FILL: begin
            if (cnt != CNT_W'(EMPTY_LAT)) cnt <= cnt + CNT_W'(1);
            if (cnt == CNT_W'(EMPTY_LAT - 1)) emptyFlag <= 1'b0;
            if (strb.wrInc && wrLast) begin
              fullFlag    <= 1'b1;
              state       <= ST_WAIT;
              convStandby <= stbyAfter;
            end
          end
          ST_CONT: begin
            emptyFlag <= 1'b0;
            if (trig) begin
              fullFlag    <= 1'b1;
              state       <= ST_WAIT;
              convStandby <= stbyAfter;
            end
          end
          ST_WAIT: if (dumpReq) state <= ST_READ;
          ST_READ: if (rdLast) begin
            state     <= ST_IDLE;
            emptyFlag <= 1'b1;
            fullFlag  <= 1'b0;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/snapshot_capture.sv
module snapshot_capture
  import snap_pkg::*;
#(
  parameter int DATA_W    = 12,
  parameter int ADDR_W    = 14,
  parameter int LEN_W     = 8,
  parameter int BLK_W     = 6,
  parameter int HOLD_W    = 16,
  parameter int SETTLE_W  = 16,
  parameter int FILL_LAT  = 13,
  parameter int EMPTY_LAT = 24
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                fillPin,
  input  logic                swFill,
  input  logic                dumpReq,
  input  logic [1:0]          fillMode,
  input  logic [LEN_W-1:0]    fillLen,
  input  logic [HOLD_W-1:0]   holdOff,
  input  logic [SETTLE_W-1:0] settleCnt,
  input  logic                stbyAfter,
  input  logic [DATA_W-1:0]   sampleIn,
  output logic                memWe,
  output logic                memRe,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [DATA_W-1:0]   memWdata,
  output logic                fullFlag,
  output logic                emptyFlag,
  output logic                convStandby
);
  snapStrb_t strb;
  logic      wrLast, rdLast;

  assign memWdata = sampleIn;

  snap_ctrl #(
    .HOLD_W(HOLD_W), .SETTLE_W(SETTLE_W),
    .FILL_LAT(FILL_LAT), .EMPTY_LAT(EMPTY_LAT)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .fillPin(fillPin), .swFill(swFill),
    .dumpReq(dumpReq), .fillMode(fillMode), .holdOff(holdOff),
    .settleCnt(settleCnt), .stbyAfter(stbyAfter), .wrLast(wrLast),
    .rdLast(rdLast), .strb(strb), .memWe(memWe), .memRe(memRe),
    .fullFlag(fullFlag), .emptyFlag(emptyFlag), .convStandby(convStandby)
  );

  snap_dpath #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .BLK_W(BLK_W)
  ) dpath_i (
    .clk(clk), .rstN(rstN), .strb(strb), .fillLen(fillLen),
    .wrLast(wrLast), .rdLast(rdLast), .memAddr(memAddr)
  );
endmodule

// File: rtl/snapshot_capture_chk.sv
module snapshot_capture_chk #(
  parameter int ADDR_W = 14,
  parameter int LEN_W  = 8,
  parameter int BLK_W  = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              memWe,
  input logic              memRe,
  input logic              fullFlag,
  input logic              emptyFlag,
  input logic              convStandby,
  input logic [ADDR_W-1:0] memAddr,
  input logic [LEN_W-1:0]  fillLen
);
  localparam int CAP_W = ADDR_W + 1;

  AST_RW_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(memWe && memRe)); // R9
  AST_FULL_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    fullFlag |-> !memWe); // R4
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(fullFlag && emptyFlag)); // R3
  AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> ({1'b0, memAddr} < ((CAP_W'(fillLen) + CAP_W'(1)) << BLK_W))); // R2
  AST_EMPTY_AFTER_READ: assert property (@(posedge clk) disable iff (!rstN)
    $rose(emptyFlag) |-> $past(memRe)); // R9
  AST_FULL_UNTIL_READ: assert property (@(posedge clk) disable iff (!rstN)
    $fell(fullFlag) |-> $past(memRe)); // R9
  AST_STBY_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    convStandby |-> !memWe); // R11
endmodule

bind snapshot_capture snapshot_capture_chk #(
  .ADDR_W(ADDR_W), .LEN_W(LEN_W), .BLK_W(BLK_W)
) chk_i (
  .clk(clk), .rstN(rstN), .memWe(memWe), .memRe(memRe),
  .fullFlag(fullFlag), .emptyFlag(emptyFlag), .convStandby(convStandby),
  .memAddr(memAddr), .fillLen(fillLen)
);

// File: tb/snapshot_capture_tb.sv
`timescale 1ns/100ps
module snapshot_capture_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        fillPin = 1'b0, swFill = 1'b0, dumpReq = 1'b0, stbyAfter = 1'b0;
  logic [1:0]  fillMode = 2'b00;
  logic [7:0]  fillLen = 8'd0;
  logic [15:0] holdOff = 16'd0, settleCnt = 16'd0;
  logic [11:0] sampleIn = 12'd0;
  logic        memWe, memRe, fullFlag, emptyFlag, convStandby;
  logic [13:0] memAddr;
  logic [11:0] memWdata;

  int nChecks = 0, nBad = 0;
  int wrCnt = 0, wrFirst = -1, wrLastA = -1;
  int rdCnt = 0, rdFirst = -1, rdLastA = -1;
  int dataBad = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) sampleIn <= sampleIn + 12'd1;

  snapshot_capture dut_i (
    .clk(clk), .rstN(rstN), .fillPin(fillPin), .swFill(swFill),
    .dumpReq(dumpReq), .fillMode(fillMode), .fillLen(fillLen),
    .holdOff(holdOff), .settleCnt(settleCnt), .stbyAfter(stbyAfter),
    .sampleIn(sampleIn), .memWe(memWe), .memRe(memRe), .memAddr(memAddr),
    .memWdata(memWdata), .fullFlag(fullFlag), .emptyFlag(emptyFlag),
    .convStandby(convStandby)
  );

  always @(negedge clk) begin
    if (memWe) begin
      if (wrCnt == 0) wrFirst = memAddr;
      wrLastA = memAddr;
      wrCnt++;
      if (memWdata != sampleIn) dataBad++;
    end
    if (memRe) begin
      if (rdCnt == 0) rdFirst = memAddr;
      rdLastA = memAddr;
      rdCnt++;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic clearMon();
    wrCnt = 0; wrFirst = -1; wrLastA = -1;
    rdCnt = 0; rdFirst = -1; rdLastA = -1;
  endtask

  task automatic pulseFill();
    fillPin = 1'b1;
    steps(1);
    fillPin = 1'b0;
  endtask

  task automatic doRead(input int n, input int first, input int last, input string req);
    rdCnt = 0; rdFirst = -1; rdLastA = -1;
    dumpReq = 1'b1;
    steps(1);
    dumpReq = 1'b0;
    steps(n + 2);
    chk({req, " read count"}, rdCnt, n);
    chk({req, " first read addr"}, rdFirst, first);
    chk({req, " last read addr"}, rdLastA, last);
    chk({req, " empty after read"}, emptyFlag, 1);
    chk({req, " full after read"}, fullFlag, 0);
  endtask

  // R1
  task automatic testReset();
    chk("R1 empty", emptyFlag, 1);
    chk("R1 full", fullFlag, 0);
    chk("R1 standby", convStandby, 0);
    chk("R1 we", memWe, 0);
    chk("R1 re", memRe, 0);
  endtask

  // R2 R3 R4 R12 R10 R9
  task automatic testSingle();
    fillMode = 2'b00; fillLen = 8'd0;
    clearMon();
    pulseFill();
    steps(23); chk("R3 empty before 24", emptyFlag, 1);
    steps(1);  chk("R3 empty at 24", emptyFlag, 0);
    steps(52); chk("R4 full before N+13", fullFlag, 0);
    steps(1);  chk("R4 full at N+13 (R12 single)", fullFlag, 1);
    chk("R2 write count", wrCnt, 64);
    chk("R2 first write addr", wrFirst, 0);
    chk("R2 last write addr", wrLastA, 63);
    chk("R2 write data", dataBad, 0);
    pulseFill();
    steps(30);
    chk("R10 trigger while full: full", fullFlag, 1);
    chk("R10 trigger while full: writes", wrCnt, 64);
    doRead(64, 0, 63, "R9 single");
  endtask

  // R10
  task automatic testDumpIdle();
    clearMon();
    dumpReq = 1'b1;
    steps(5);
    dumpReq = 1'b0;
    steps(2);
    chk("R10 dump in idle reads", rdCnt, 0);
    chk("R10 dump in idle empty", emptyFlag, 1);
  endtask

  // R5
  task automatic testRetrigger();
    fillLen = 8'd1;
    pulseFill();
    steps(40);
    pulseFill();
    clearMon();
    steps(140); chk("R5 full not before restart+N+13", fullFlag, 0);
    steps(1);   chk("R5 full at restart+N+13", fullFlag, 1);
    chk("R5 writes after restart", wrCnt, 128);
    chk("R5 first addr after restart", wrFirst, 0);
    chk("R5 last addr after restart", wrLastA, 127);
    doRead(128, 0, 127, "R5");
    fillLen = 8'd0;
  endtask

  // R6 R7
  task automatic testSwAndHold();
    holdOff = 16'd5;
    swFill = 1'b1;
    steps(1);
    swFill = 1'b0;
    steps(23); chk("R6 sw empty before 24", emptyFlag, 1);
    steps(1);  chk("R6 sw empty at 24", emptyFlag, 0);
    steps(53); chk("R6 sw full at N+13", fullFlag, 1);
    doRead(64, 0, 63, "R6");
    pulseFill();
    steps(28); chk("R7 empty before 24+H", emptyFlag, 1);
    steps(1);  chk("R7 empty at 24+H", emptyFlag, 0);
    steps(52); chk("R7 full before N+13+H", fullFlag, 0);
    steps(1);  chk("R7 full at N+13+H", fullFlag, 1);
    doRead(64, 0, 63, "R7");
    holdOff = 16'd0;
  endtask

  // R8 R9 R12
  task automatic testContinuous();
    fillMode = 2'b01; fillLen = 8'd0;
    clearMon();
    pulseFill();
    steps(99);
    pulseFill();
    chk("R8 full at stop edge (R12 cont)", fullFlag, 1);
    steps(3);
    chk("R8 writes until stop", wrCnt, 100);
    chk("R8 wrapped last addr", wrLastA, 35);
    doRead(64, 36, 35, "R9 wrapped oldest");
    clearMon();
    pulseFill();
    steps(9);
    pulseFill();
    chk("R8 short stop full", fullFlag, 1);
    chk("R8 short writes", wrCnt, 10);
    doRead(10, 0, 9, "R9 unwrapped");
    fillMode = 2'b00;
  endtask

  // R11
  task automatic testStandby();
    stbyAfter = 1'b1; settleCnt = 16'd7;
    pulseFill();
    steps(77);
    chk("R11 full", fullFlag, 1);
    chk("R11 standby after capture", convStandby, 1);
    doRead(64, 0, 63, "R11 first");
    stbyAfter = 1'b0;
    clearMon();
    pulseFill();
    chk("R11 standby cleared by trigger", convStandby, 0);
    steps(19); chk("R11 no write during settle", wrCnt, 0);
    steps(11); chk("R11 empty before 24+S", emptyFlag, 1);
    steps(1);  chk("R11 empty at 24+S", emptyFlag, 0);
    steps(52); chk("R11 full before N+13+S", fullFlag, 0);
    steps(1);  chk("R11 full at N+13+S", fullFlag, 1);
    chk("R11 writes", wrCnt, 64);
    doRead(64, 0, 63, "R11 second");
    settleCnt = 16'd0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nBad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end

  initial begin
    steps(3);
    rstN = 1'b1;
    steps(2);
    testReset();
    testSingle();
    testDumpIdle();
    testRetrigger();
    testSwAndHold();
    testContinuous();
    testStandby();
    $display("  test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end
endmodule